// File: doc/BRIEF.md
# USB Host Controller Register Bank

This block holds the programmed-I/O registers of a two-port full/low-speed USB host controller. The host reaches it through a 32-byte I/O window with byte, halfword and word accesses. Reads are combinational from the address and size. Writes take effect on the next rising clock edge. The registers are command, status, interrupt enable, frame number, frame list base, start-of-frame timing, and one status/control register for each root port.

The frame engine reports completions and errors by one-cycle pulses. The root ports report attach, detach and remote wakeup the same way. The block folds these events into status bits and port bits. It drives one level-sensitive interrupt line from the latched status and the interrupt enables. A hidden two-bit latch keeps completion interrupts apart from short-packet interrupts, so that each has its own enable.

Top module: `usbhc_regbank`

## Requirements
- R1: After the synchronous active-high reset, the following values hold and the interrupt line is low:
  - start-of-frame timing reads 64;
  - each port register reads 0x0080;
  - command, status, interrupt enable, frame number and frame list base read zero.
- R2: A halfword write to the command register at 0x00 stores the written value. When run/stop (bit 0) goes from 0 to 1, halted (status bit 5) clears. When the written run/stop is 0, halted sets.
- R3: A command write that has host-controller reset (bit 1) or global reset (bit 2) set returns every register, including the hidden latch, to its R1 value. The written value is not stored.
- R4: A halfword write to status at 0x02 clears each status bit written as one. Writing one to bit 0 also clears the hidden two-bit latch; writing zero to bit 0 leaves the latch unchanged.
- R5: The interrupt line is high if and only if at least one of these holds:
  - latch bit 0 with enable bit 2;
  - latch bit 1 with enable bit 3;
  - status bit 1 with enable bit 0;
  - status bit 2 with enable bit 1;
  - status bit 3;
  - status bit 4.

  The enable register is a halfword at 0x04.
- R6: The frame number at 0x06 is 11 bits wide. It accepts a write only while halted; otherwise the write is ignored.
- R7: A word write to the frame list base at 0x08 stores the value with its low 12 bits forced to zero.
- R8: The start-of-frame timing register is a byte at 0x0C. A byte write to any other offset changes no register.
- R9: A halfword write to a port register (port n at 0x10+2n) is applied in three parts:
  - bits in mask 0x01BB keep their value;
  - bits 1 and 3 then clear where the written value has a one;
  - all other bits take the written value.
- R10: On attach, a port sets bits 0 and 1, and bit 8 takes the low-speed input. On detach, if bit 0 is set, it clears and bit 1 sets; if enable (bit 2) is set, it clears and bit 3 sets.
- R11: A wakeup on a port sets port bit 6 only when bit 12 is set and bit 6 is clear. While command bit 3 is set, an attach, a detach or such a qualifying wakeup sets command bit 4 and status bit 2.
- R12: Reads of unmapped locations return fixed values:
  - an unmapped halfword, including port index 2 or more, reads 0xFF7F;
  - an unmapped word reads 0xFFFFFFFF;
  - an unmapped byte reads 0xFF.

  The size encoding is 0 byte, 1 halfword, 2 word.
- R13: The frame-engine pulses each set status bits:
  - a completion pulse sets latch bit 0 and status bit 0;
  - a short-packet pulse sets latch bit 1 and status bit 0;
  - the error pulses set status bit 1 (transfer error), bit 3 (system error) or bit 4 (process error).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 5 | Byte offset inside the I/O window |
| busSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| busWr | input | 1 | Write strobe for the current access |
| busWdata | input | 32 | Write data, right-aligned |
| busRdata | output | 32 | Read data for the current address and size |
| attachEv | input | 2 | Per-port device attach pulse |
| detachEv | input | 2 | Per-port device detach pulse |
| wakeEv | input | 2 | Per-port remote wakeup pulse |
| lowSpeed | input | 2 | Per-port speed of the attaching device (1 = low speed) |
| frmIoc | input | 1 | Frame engine: completion interrupt pulse |
| frmShort | input | 1 | Frame engine: short-packet interrupt pulse |
| frmUsbErr | input | 1 | Frame engine: transfer error pulse |
| frmHostErr | input | 1 | Frame engine: host system error pulse |
| frmProcErr | input | 1 | Frame engine: process error pulse |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
A wrong bit in the hidden latch, a missed write-one-to-clear or a lost status event shows on the interrupt line in the cycle after the event. It also shows in the next status or port read. The interrupt check runs every enable pattern against every interrupt source, so a misrouted enable bit appears within one access. The port check sweeps write patterns against a bench model of the read-only, write-one-to-clear and plain fields. A mis-masked bit therefore diverges on the first read that follows the faulty write.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;
  localparam int NUM_PORTS    = 2;
  localparam int PIDX_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int FRAME_BITS   = 11;
  localparam int FLBASE_ALIGN = 12;
  localparam int ADDR_W       = 5;
  localparam logic [7:0]  SOF_RESET    = 8'd64;
  localparam logic [15:0] PORT_RESET   = 16'h0080;
  localparam logic [15:0] PORT_RO_MASK = 16'h01BB;
  localparam logic [15:0] PORT_W1C     = 16'h000A;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    RD_NONE, RD_CMD, RD_STS, RD_INTR, RD_FRNUM, RD_PORT,
    RD_FLBASE, RD_SOF, RD_BAD_H, RD_BAD_W, RD_BAD_B
  } rdSel_e;

  typedef struct packed {
    logic                 wrCmd;
    logic                 wrSts;
    logic                 wrIntr;
    logic                 wrFrnum;
    logic                 wrFlbase;
    logic                 wrSof;
    logic [NUM_PORTS-1:0] wrPort;
    logic                 doReset;
  } regStb_t;
endpackage

// File: rtl/usbhc_ctrl.sv
module usbhc_ctrl
  import usbhc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busWr,
  input  logic [2:1]        rstBits,
  output regStb_t           stb,
  output rdSel_e            rdSel,
  output logic [PIDX_W-1:0] portIdx
);
  always_comb begin
    stb     = '0;
    rdSel   = RD_NONE;
    portIdx = '0;
    unique case (busSize)
      SZ_BYTE: begin
        if (busAddr == 5'h0C) begin
          rdSel     = RD_SOF;
          stb.wrSof = busWr;
        end else begin
          rdSel = RD_BAD_B;
        end
      end
      SZ_HALF: begin
        if (busAddr[4]) begin
          if (busAddr[3:1] < 3'(NUM_PORTS)) begin
            rdSel   = RD_PORT;
            portIdx = busAddr[1 +: PIDX_W];
            for (int p = 0; p < NUM_PORTS; p++)
              if (busAddr[3:1] == 3'(p)) stb.wrPort[p] = busWr;
          end else begin
            rdSel = RD_BAD_H;
          end
        end else begin
          unique case (busAddr)
            5'h00: begin rdSel = RD_CMD;   stb.wrCmd   = busWr; end
            5'h02: begin rdSel = RD_STS;   stb.wrSts   = busWr; end
            5'h04: begin rdSel = RD_INTR;  stb.wrIntr  = busWr; end
            5'h06: begin rdSel = RD_FRNUM; stb.wrFrnum = busWr; end
            default: rdSel = RD_BAD_H;
          endcase
        end
      end
      SZ_WORD: begin
        if (busAddr == 5'h08) begin
          rdSel        = RD_FLBASE;
          stb.wrFlbase = busWr;
        end else begin
          rdSel = RD_BAD_W;
        end
      end
      default: rdSel = RD_NONE;
    endcase
    stb.doReset = stb.wrCmd & (|rstBits);
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.wrCmd, stb.wrSts, stb.wrIntr, stb.wrFrnum, stb.wrFlbase, stb.wrSof, stb.wrPort}))
    else $error("write reaches more than one register"); // R8
endmodule

// File: rtl/usbhc_regs.sv
module usbhc_regs
  import usbhc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  regStb_t              stb,
  input  rdSel_e               rdSel,
  input  logic [PIDX_W-1:0]    portIdx,
  input  logic [31:0]          wdata,
  input  logic                 evIoc,
  input  logic                 evShort,
  input  logic                 evUsbErr,
  input  logic                 evHostErr,
  input  logic                 evProcErr,
  input  logic [NUM_PORTS-1:0] attachEv,
  input  logic [NUM_PORTS-1:0] detachEv,
  input  logic [NUM_PORTS-1:0] wakeEv,
  input  logic [NUM_PORTS-1:0] lowSpeed,
  output logic [31:0]          rdData,
  output logic                 irq
);
  logic [15:0]           cmdR, cmdN;
  logic [5:0]            stsR, stsN;
  logic [15:0]           intrR, intrN;
  logic [FRAME_BITS-1:0] frnR, frnN;
  logic [31:0]           flBaseR, flBaseN;
  logic [7:0]            sofR, sofN;
  logic [1:0]            latchR, latchN;
  logic [15:0]           portR [NUM_PORTS];
  logic [15:0]           portN [NUM_PORTS];
  logic [NUM_PORTS-1:0]  wakeHit;
  logic                  resumeEv;

  always_comb begin
    cmdN    = cmdR;
    stsN    = stsR;
    intrN   = intrR;
    frnN    = frnR;
    flBaseN = flBaseR;
    sofN    = sofR;
    latchN  = latchR;
    wakeHit = '0;

    if (stb.wrCmd) begin
      cmdN = wdata[15:0];
      if (wdata[0] && !cmdR[0]) stsN[5] = 1'b0;
      else if (!wdata[0])       stsN[5] = 1'b1;
    end
    if (stb.wrSts) begin
      stsN = stsN & ~wdata[5:0];
      if (wdata[0]) latchN = 2'b00;
    end
    if (stb.wrIntr)                frnN = frnN; // no frame side effect
    if (stb.wrIntr)                intrN = wdata[15:0];
    if (stb.wrFrnum && stsR[5])    frnN = wdata[FRAME_BITS-1:0];
    if (stb.wrFlbase)              flBaseN = {wdata[31:FLBASE_ALIGN], {FLBASE_ALIGN{1'b0}}};
    if (stb.wrSof)                 sofN = wdata[7:0];

    if (evIoc)     begin latchN[0] = 1'b1; stsN[0] = 1'b1; end
    if (evShort)   begin latchN[1] = 1'b1; stsN[0] = 1'b1; end
    if (evUsbErr)  stsN[1] = 1'b1;
    if (evHostErr) stsN[3] = 1'b1;
    if (evProcErr) stsN[4] = 1'b1;

    for (int p = 0; p < NUM_PORTS; p++) begin
      portN[p] = portR[p];
      if (stb.wrPort[p]) begin
        portN[p] = (portR[p] & PORT_RO_MASK) | (wdata[15:0] & ~PORT_RO_MASK);
        portN[p] = portN[p] & ~(wdata[15:0] & PORT_W1C);
      end
      if (attachEv[p]) begin
        portN[p][1:0] = 2'b11;
        portN[p][8]   = lowSpeed[p];
      end
      if (detachEv[p]) begin
        if (portN[p][0]) begin portN[p][0] = 1'b0; portN[p][1] = 1'b1; end
        if (portN[p][2]) begin portN[p][2] = 1'b0; portN[p][3] = 1'b1; end
      end
      if (wakeEv[p] && portN[p][12] && !portN[p][6]) begin
        portN[p][6] = 1'b1;
        wakeHit[p]  = 1'b1;
      end
    end

    resumeEv = (|attachEv) | (|detachEv) | (|wakeHit);
    if (resumeEv && cmdN[3]) begin
      cmdN[4] = 1'b1;
      stsN[2] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stb.doReset) begin
      cmdR    <= '0;
      stsR    <= '0;
      intrR   <= '0;
      frnR    <= '0;
      flBaseR <= '0;
      sofR    <= SOF_RESET;
      latchR  <= '0;
      for (int p = 0; p < NUM_PORTS; p++) portR[p] <= PORT_RESET;
    end else begin
      cmdR    <= cmdN;
      stsR    <= stsN;
      intrR   <= intrN;
      frnR    <= frnN;
      flBaseR <= flBaseN;
      sofR    <= sofN;
      latchR  <= latchN;
      for (int p = 0; p < NUM_PORTS; p++) portR[p] <= portN[p];
    end
  end

  assign irq = (latchR[0] & intrR[2]) | (latchR[1] & intrR[3]) |
               (stsR[1] & intrR[0])   | (stsR[2] & intrR[1])   |
               stsR[3] | stsR[4];

  always_comb begin
    unique case (rdSel)
      RD_CMD:    rdData = {16'h0, cmdR};
      RD_STS:    rdData = {26'h0, stsR};
      RD_INTR:   rdData = {16'h0, intrR};
      RD_FRNUM:  rdData = {{(32-FRAME_BITS){1'b0}}, frnR};
      RD_PORT:   rdData = {16'h0, portR[portIdx]};
      RD_FLBASE: rdData = flBaseR;
      RD_SOF:    rdData = {24'h0, sofR};
      RD_BAD_H:  rdData = 32'h0000FF7F;
      RD_BAD_W:  rdData = 32'hFFFFFFFF;
      RD_BAD_B:  rdData = 32'h000000FF;
      default:   rdData = 32'h0;
    endcase
  end

  AST_RUN_CLEARS_HALT: assert property (@(posedge clk) disable iff (rst)
    (stb.wrCmd && wdata[0] && !cmdR[0] && !stb.doReset) |=> !stsR[5])
    else $error("run start left halted set"); // R2
  AST_FRNUM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stsR[5] && !stb.doReset) |=> $stable(frnR))
    else $error("frame number moved while running"); // R6
  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stb.wrSts && wdata[0] && !evIoc && !evShort) |=> (latchR == 2'b00))
    else $error("latch survived status clear"); // R4
  AST_SYSERR_IRQ: assert property (@(posedge clk) disable iff (rst)
    (stsR[3] || stsR[4]) |-> irq)
    else $error("system error without interrupt"); // R5
  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPortChk
    AST_PORT_FIXED: assert property (@(posedge clk) disable iff (rst)
      portR[g][7])
      else $error("fixed port bit lost"); // R9
  end
endmodule

// File: rtl/usbhc_regbank.sv
module usbhc_regbank
  import usbhc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [1:0]           busSize,
  input  logic                 busWr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_PORTS-1:0] attachEv,
  input  logic [NUM_PORTS-1:0] detachEv,
  input  logic [NUM_PORTS-1:0] wakeEv,
  input  logic [NUM_PORTS-1:0] lowSpeed,
  input  logic                 frmIoc,
  input  logic                 frmShort,
  input  logic                 frmUsbErr,
  input  logic                 frmHostErr,
  input  logic                 frmProcErr,
  output logic                 irq
);
  regStb_t           stb;
  rdSel_e            rdSel;
  logic [PIDX_W-1:0] portIdx;

  usbhc_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .busAddr (busAddr),
    .busSize (busSize),
    .busWr   (busWr),
    .rstBits (busWdata[2:1]),
    .stb     (stb),
    .rdSel   (rdSel),
    .portIdx (portIdx)
  );

  usbhc_regs i_regs (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .rdSel     (rdSel),
    .portIdx   (portIdx),
    .wdata     (busWdata),
    .evIoc     (frmIoc),
    .evShort   (frmShort),
    .evUsbErr  (frmUsbErr),
    .evHostErr (frmHostErr),
    .evProcErr (frmProcErr),
    .attachEv  (attachEv),
    .detachEv  (detachEv),
    .wakeEv    (wakeEv),
    .lowSpeed  (lowSpeed),
    .rdData    (busRdata),
    .irq       (irq)
  );
endmodule

// File: tb/test_usbhc_regbank.sv
module test_usbhc_regbank;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RO  = 16'h01BB;
  localparam logic [15:0] W1C = 16'h000A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  attachEv = '0, detachEv = '0, wakeEv = '0, lowSpeed = '0;
  logic        frmIoc = 0, frmShort = 0, frmUsbErr = 0, frmHostErr = 0, frmProcErr = 0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;
  logic [15:0] pm;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbhc_regbank i_usbhc_regbank (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busSize(busSize), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .attachEv(attachEv),
    .detachEv(detachEv), .wakeEv(wakeEv), .lowSpeed(lowSpeed),
    .frmIoc(frmIoc), .frmShort(frmShort), .frmUsbErr(frmUsbErr),
    .frmHostErr(frmHostErr), .frmProcErr(frmProcErr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busSize = sz; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busSize = sz; busWr = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic pulse(input int which, input logic [1:0] pm2, input logic [1:0] ls);
    @(negedge clk);
    lowSpeed = ls;
    case (which)
      0: frmIoc = 1;     1: frmShort = 1;   2: frmUsbErr = 1;
      3: frmHostErr = 1; 4: frmProcErr = 1; 5: attachEv = pm2;
      6: detachEv = pm2; default: wakeEv = pm2;
    endcase
    @(negedge clk);
    frmIoc = 0; frmShort = 0; frmUsbErr = 0; frmHostErr = 0; frmProcErr = 0;
    attachEv = '0; detachEv = '0; wakeEv = '0;
  endtask

  task automatic irqChk(input string req, input logic exp);
    @(negedge clk);
    #1 chk(req, {31'h0, irq}, {31'h0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    rd(5'h00, 1, rv); chk("R1 cmd", rv, 0);
    rd(5'h02, 1, rv); chk("R1 sts", rv, 0);
    rd(5'h04, 1, rv); chk("R1 intr", rv, 0);
    rd(5'h06, 1, rv); chk("R1 frnum", rv, 0);
    rd(5'h08, 2, rv); chk("R1 flbase", rv, 0);
    rd(5'h0C, 0, rv); chk("R1 sof", rv, 64);
    rd(5'h10, 1, rv); chk("R1 port0", rv, 16'h0080);
    rd(5'h12, 1, rv); chk("R1 port1", rv, 16'h0080);
    irqChk("R1 irq", 0);

    // R6 frame number gated by halted
    wr(5'h06, 1, 32'h0123); rd(5'h06, 1, rv); chk("R6 write while not halted", rv, 0);
    wr(5'h00, 1, 32'h0000); rd(5'h02, 1, rv); chk("R2 run=0 sets halted", rv, 32'h20);
    wr(5'h06, 1, 32'hFFFF); rd(5'h06, 1, rv); chk("R6 11-bit write", rv, 32'h7FF);
    wr(5'h00, 1, 32'h0001); rd(5'h02, 1, rv); chk("R2 run start clears halted", rv, 0);
    rd(5'h00, 1, rv); chk("R2 cmd stored", rv, 1);
    wr(5'h06, 1, 32'h0005); rd(5'h06, 1, rv); chk("R6 write ignored while running", rv, 32'h7FF);

    // R7, R8, R12
    wr(5'h08, 2, 32'h12345678); rd(5'h08, 2, rv); chk("R7 flbase aligned", rv, 32'h12345000);
    wr(5'h0C, 0, 32'hA5); rd(5'h0C, 0, rv); chk("R8 sof byte", rv, 32'hA5);
    wr(5'h0D, 0, 32'h77); rd(5'h0C, 0, rv); chk("R8 stray byte sof", rv, 32'hA5);
    rd(5'h08, 2, rv); chk("R8 stray byte flbase", rv, 32'h12345000);
    rd(5'h06, 1, rv); chk("R8 stray byte frnum", rv, 32'h7FF);
    rd(5'h08, 1, rv); chk("R12 half unmapped", rv, 32'hFF7F);
    rd(5'h14, 1, rv); chk("R12 port index 2", rv, 32'hFF7F);
    rd(5'h1E, 1, rv); chk("R12 port index 7", rv, 32'hFF7F);
    rd(5'h0C, 2, rv); chk("R12 word unmapped", rv, 32'hFFFFFFFF);
    rd(5'h00, 0, rv); chk("R12 byte unmapped", rv, 32'hFF);

    // R9 port write sweep on port 1 against a bench model
    pm = 16'h0080;
    for (int k = 0; k < 32; k++) begin
      logic [15:0] v;
      if (k % 4 == 0) begin
        pulse(5, 2'b10, {k[2], 1'b0});
        pm[1:0] = 2'b11; pm[8] = k[2];
      end
      v = 16'(k * 16'h0F35 + 16'h1234);
      wr(5'h12, 1, {16'h0, v});
      pm = ((pm & RO) | (v & ~RO)) & ~(v & W1C);
      rd(5'h12, 1, rv); chk("R9 port sweep", rv, {16'h0, pm});
    end

    // R10 attach / detach on port 0
    pulse(5, 2'b01, 2'b01); rd(5'h10, 1, rv); chk("R10 attach low speed", rv, 32'h0183);
    wr(5'h10, 1, 32'h0004); rd(5'h10, 1, rv); chk("R9 enable write", rv, 32'h0187);
    wr(5'h10, 1, 32'h000E); rd(5'h10, 1, rv); chk("R9 w1c clear", rv, 32'h0185);
    pulse(6, 2'b01, 2'b00); rd(5'h10, 1, rv); chk("R10 detach", rv, 32'h018A);
    pulse(6, 2'b01, 2'b00); rd(5'h10, 1, rv); chk("R10 second detach no effect", rv, 32'h018A);

    // R11 wakeup and resume
    wr(5'h00, 1, 32'h0009);
    wr(5'h10, 1, 32'h1000); rd(5'h10, 1, rv); chk("R9 suspend bit", rv, 32'h118A);
    pulse(7, 2'b01, 2'b00); rd(5'h10, 1, rv); chk("R11 wake sets bit6", rv, 32'h11CA);
    rd(5'h00, 1, rv); chk("R11 force resume", rv, 32'h0019);
    rd(5'h02, 1, rv); chk("R11 resume detect", rv, 32'h04);
    wr(5'h02, 1, 32'h0004); rd(5'h02, 1, rv); chk("R4 clear resume", rv, 0);
    pulse(7, 2'b01, 2'b00); rd(5'h02, 1, rv); chk("R11 repeated wake ignored", rv, 0);
    rd(5'h10, 1, rv); chk("R11 repeated wake port", rv, 32'h11CA);

    // R3 reset through command
    wr(5'h00, 1, 32'h0004);
    rd(5'h00, 1, rv); chk("R3 cmd", rv, 0);
    rd(5'h0C, 0, rv); chk("R3 sof", rv, 64);
    rd(5'h10, 1, rv); chk("R3 port0", rv, 32'h80);
    rd(5'h12, 1, rv); chk("R3 port1", rv, 32'h80);
    rd(5'h08, 2, rv); chk("R3 flbase", rv, 0);
    rd(5'h06, 1, rv); chk("R3 frnum", rv, 0);
    rd(5'h02, 1, rv); chk("R3 sts", rv, 0);

    // R5 / R13 sweep: every enable pattern against every enabled source
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [3:0] mk;
        logic expIrq;
        logic [31:0] expSts;
        mk = 4'(m);
        wr(5'h00, 1, 32'h0002);
        wr(5'h04, 1, {28'h0, mk});
        case (s)
          0: begin pulse(0, 2'b00, 2'b00); expIrq = mk[2]; expSts = 32'h01; end
          1: begin pulse(1, 2'b00, 2'b00); expIrq = mk[3]; expSts = 32'h01; end
          2: begin pulse(2, 2'b00, 2'b00); expIrq = mk[0]; expSts = 32'h02; end
          default: begin
            wr(5'h00, 1, 32'h0008);
            pulse(5, 2'b01, 2'b00);
            expIrq = mk[1]; expSts = 32'h24;
          end
        endcase
        irqChk("R5 irq sweep", expIrq);
        rd(5'h02, 1, rv); chk("R13 status sweep", rv, expSts);
      end
    end

    // R4 hidden latch
    wr(5'h00, 1, 32'h0002); wr(5'h04, 1, 32'h0004);
    pulse(1, 2'b00, 2'b00); irqChk("R4 short not on completion enable", 0);
    pulse(0, 2'b00, 2'b00); irqChk("R13 completion irq", 1);
    wr(5'h02, 1, 32'h0002); irqChk("R4 latch kept without bit0", 1);
    wr(5'h02, 1, 32'h0001); irqChk("R4 latch cleared", 0);
    rd(5'h02, 1, rv); chk("R4 status cleared", rv, 0);

    // R13 system errors always interrupt
    wr(5'h04, 1, 32'h0000);
    pulse(3, 2'b00, 2'b00); irqChk("R5 host error irq", 1);
    rd(5'h02, 1, rv); chk("R13 host error bit", rv, 32'h08);
    wr(5'h02, 1, 32'h0008); irqChk("R4 host error clear", 0);
    pulse(4, 2'b00, 2'b00); irqChk("R5 process error irq", 1);
    rd(5'h02, 1, rv); chk("R13 process error bit", rv, 32'h10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule